// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block connects a clocked host to an external 128K x 8 asynchronous static RAM. The host offers one request at a time through a valid/ready handshake: a write flag, a 17-bit address and a byte of write data. The controller then runs one complete memory cycle on the pins. Those pins are an address bus, an active-low select and an active-high select, an active-low write strobe, an active-low output enable and a data bus. The data bus is split into an outgoing byte, an incoming byte and a drive enable for the pad.

Each phase of a cycle lasts a whole number of clocks. That count is worked out at elaboration from a nanosecond parameter and the clock period, by rounding up with a floor of one clock. In a write, the strobe stays low until the pulse width, the data setup and the address setup are all met. A hold clock follows in which the data is still driven. In a read, the output enable stays low until the access times from address, select and output enable have all passed. The byte is sampled on the edge that ends that window and is handed back to the host with a one-clock valid pulse. Between requests the memory is deselected, so it sits in its low-power state.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A write drives `mem_we_n` low for exactly WP_CYC clocks, the largest of ceil(T_WP/T_CLK), ceil(T_SD/T_CLK) and ceil(T_AW/T_CLK), each at least 1. This is 6 clocks at the defaults (8 ns clock, 45/25/45 ns). Throughout, `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=1 and `mem_dq_oe`=1.
- R3: During a write cycle, `mem_addr` and `mem_dq_out` equal the address and data accepted with the request and do not change.
- R4: After `mem_we_n` rises, the chip stays selected with the data still driven for HOLD_CYC clocks: max(1, WC_CYC-WP_CYC), with WC_CYC=ceil(T_WC/T_CLK). This is 1 clock at the defaults, so the write lasts at least 7 clocks in total.
- R5: A read holds `mem_oe_n` low, `mem_we_n` high and the chip selected for exactly RD_CYC clocks, the largest of the rounded-up T_RC, T_AA, T_ACE and T_DOE. This is 7 clocks at the defaults.
- R6: `resp_valid` is high for exactly one clock, in the clock after `mem_oe_n` rises, which is RD_CYC+1 clocks after acceptance. `resp_rdata` then carries the byte present on `mem_dq_in` in the last clock of the read window.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: When `mem_dq_oe` rises, `mem_oe_n` was already high and `mem_dq_oe` was already low in the clock before.
- R9: A request is taken only on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole cycle, and changes on the request inputs during the cycle have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| resp_valid | output | 1 | One-clock read data valid |
| resp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
The memory model in the bench only presents a real byte after the output enable has been low for the full access window. Before that it returns a junk pattern, so a read window one clock short hands the host wrong data. Each strobe low time and each hold phase is measured. A shortened pulse or a released bus at the rising strobe shows up as a wrong count or as a wrong byte stored in the model. Read-then-write sequences, extreme addresses and data, and request inputs scrambled while a cycle runs are all used. These catch bus contention across the turnaround, a latched address that follows the live inputs, and a response pulse longer than one clock.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_WAIT,
        ST_RD_END
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   sel_n;
        logic   sel;
        logic   we_n;
        logic   oe_n;
        logic   dq_oe;
        logic   resp_valid;
    } ctrl_t;

    // Round a nanosecond figure up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d, rdata_d;

    always_comb begin
        addr_d  = addr_q;
        wdata_d = wdata_q;
        rdata_d = rdata_q;
        if (accept) begin
            addr_d  = req_addr;
            wdata_d = req_wdata;
        end
        if (capture) begin
            rdata_d = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            rdata_q <= rdata_d;
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_WC_NS   = 55,
    parameter int unsigned T_WP_NS   = 45,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_AW_NS   = 45,
    parameter int unsigned T_RC_NS   = 55,
    parameter int unsigned T_AA_NS   = 55,
    parameter int unsigned T_ACE_NS  = 55,
    parameter int unsigned T_DOE_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned WP_CYC   = max2(max2(ns_to_clk(T_WP_NS, CLK_NS),
                                                 ns_to_clk(T_SD_NS, CLK_NS)),
                                            ns_to_clk(T_AW_NS, CLK_NS));
    localparam int unsigned WC_CYC   = ns_to_clk(T_WC_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned RD_CYC   = max2(max2(ns_to_clk(T_RC_NS, CLK_NS),
                                                 ns_to_clk(T_AA_NS, CLK_NS)),
                                            max2(ns_to_clk(T_ACE_NS, CLK_NS),
                                                 ns_to_clk(T_DOE_NS, CLK_NS)));
    localparam int unsigned MAX_CYC  = max2(max2(WP_CYC, HOLD_CYC), RD_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    ctrl_t            st_d, st_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             accept;
    logic             capture;

    localparam ctrl_t IDLE_CTRL = '{phase: ST_IDLE, sel_n: 1'b1, sel: 1'b0,
                                    we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0,
                                    resp_valid: 1'b0};

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        tmr_load        = 1'b0;
        tmr_val         = '0;
        accept          = 1'b0;
        capture         = 1'b0;
        unique case (st_q.phase)
            ST_IDLE: begin
                st_d = IDLE_CTRL;
                if (req_valid) begin
                    accept     = 1'b1;
                    tmr_load   = 1'b1;
                    st_d.sel_n = 1'b0;
                    st_d.sel   = 1'b1;
                    if (req_write) begin
                        st_d.phase = ST_WR_PULSE;
                        st_d.we_n  = 1'b0;
                        st_d.dq_oe = 1'b1;
                        tmr_val    = CNT_W'(WP_CYC);
                    end else begin
                        st_d.phase = ST_RD_WAIT;
                        st_d.oe_n  = 1'b0;
                        tmr_val    = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    st_d.phase = ST_WR_HOLD;
                    st_d.we_n  = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(HOLD_CYC);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_done) begin
                    st_d = IDLE_CTRL;
                end
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    capture         = 1'b1;
                    st_d            = IDLE_CTRL;
                    st_d.phase      = ST_RD_END;
                    st_d.resp_valid = 1'b1;
                end
            end
            ST_RD_END: begin
                st_d = IDLE_CTRL;
            end
            default: st_d = IDLE_CTRL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE_CTRL;
        else        st_q <= st_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (resp_rdata)
    );

    assign req_ready  = (st_q.phase == ST_IDLE);
    assign resp_valid = st_q.resp_valid;
    assign mem_sel_n  = st_q.sel_n;
    assign mem_sel    = st_q.sel;
    assign mem_we_n   = st_q.we_n;
    assign mem_oe_n   = st_q.oe_n;
    assign mem_dq_oe  = st_q.dq_oe;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_oe_n && mem_dq_oe));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$rose(mem_sel)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_sel_n && mem_sel && $stable(mem_dq_out)));

    a_r5_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n && mem_sel));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && !$past(mem_dq_oe)));

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n) |-> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb;
    localparam int AW = 17;
    localparam int DW = 8;

    function automatic int ceil_clk(input int ns);
        int c;
        c = (ns + 7) / 8;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WP   = 6;
    localparam int HOLD = 1;
    localparam int RD   = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_valid;
    logic [DW-1:0] resp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sram_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model and host shadow
    logic [DW-1:0] model_mem [logic [AW-1:0]];
    logic [DW-1:0] shadow    [logic [AW-1:0]];

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return a[7:0] ^ {a[16:15], a[14:9]} ^ 8'h3C;
    endfunction

    int rd_cnt = 0;
    logic rd_cond;
    assign rd_cond = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
    always_comb begin
        if (rd_cond && rd_cnt >= RD)
            mem_dq_in = model_mem.exists(mem_addr) ? model_mem[mem_addr] : init_val(mem_addr);
        else
            mem_dq_in = 8'hE7;
    end

    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    int   we_cnt = 0, oe_cnt = 0, hold_cnt = 0;
    bit   in_hold = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            rd_cnt <= rd_cond ? rd_cnt + 1 : 0;
            if (mem_dq_oe && !mem_oe_n) check(0, "R7", 1, 0);
            if (mem_dq_oe && !prev_dq_oe)
                check(prev_oe_n && mem_oe_n, "R8", {31'd0, prev_oe_n}, 1);
            if (req_ready)
                if (!(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe))
                    check(0, "R1", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
            if (!mem_we_n) begin
                we_cnt++;
                if (!(mem_addr == cur_addr && mem_dq_out == cur_data))
                    check(0, "R3", {mem_addr, mem_dq_out}, {cur_addr, cur_data});
            end
            if (!mem_oe_n) oe_cnt++;
            if (prev_we_n == 1'b0 && mem_we_n) begin
                check(we_cnt == WP, "R2", we_cnt, WP);
                check(mem_dq_oe && !mem_sel_n && mem_sel, "R4",
                      {mem_dq_oe, mem_sel_n, mem_sel}, 3'b101);
                check(mem_addr == cur_addr && mem_dq_out == cur_data, "R3",
                      {mem_addr, mem_dq_out}, {cur_addr, cur_data});
                model_mem[mem_addr] = mem_dq_out;
                we_cnt   = 0;
                in_hold  = 1;
                hold_cnt = 1;
            end else if (in_hold) begin
                if (!mem_sel_n && mem_dq_oe) hold_cnt++;
                else begin
                    check(hold_cnt == HOLD && WP + hold_cnt >= ceil_clk(55), "R4", hold_cnt, HOLD);
                    in_hold = 0;
                end
            end
            if (prev_oe_n == 1'b0 && mem_oe_n) begin
                check(oe_cnt == RD && RD == imax(ceil_clk(55), ceil_clk(25)), "R5", oe_cnt, RD);
                oe_cnt = 0;
            end
            prev_we_n  <= mem_we_n;
            prev_oe_n  <= mem_oe_n;
            prev_dq_oe <= mem_dq_oe;
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int k;
        logic [DW-1:0] exp;
        while (!req_ready) @(negedge clk);
        cur_addr  = a;
        cur_data  = wr ? d : mem_dq_out;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        k = 1;
        check(!req_ready, "R9", {31'd0, req_ready}, 0);
        req_valid = 1'b0;
        req_write = $urandom() % 2 == 0;
        req_addr  = AW'($urandom());
        req_wdata = DW'($urandom());
        if (wr) begin
            shadow[a] = d;
            while (!req_ready && k < 40) begin @(negedge clk); k++; end
            check(k == WP + HOLD + 1, "R9", k, WP + HOLD + 1);
        end else begin
            exp = shadow.exists(a) ? shadow[a] : init_val(a);
            while (!resp_valid && k < 40) begin @(negedge clk); k++; end
            check(k == RD + 1, "R6", k, RD + 1);
            check(resp_rdata == exp, "R6", resp_rdata, exp);
            @(negedge clk);
            check(!resp_valid, "R6", {31'd0, resp_valid}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(req_ready && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !resp_valid,
              "R1", {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b110110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_sel_n && !mem_sel, "R1", {req_ready, mem_sel_n, mem_sel}, 3'b110);
        // Directed corners
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h1FFFF, 8'hFF);
        do_op(1'b1, 17'h00000, 8'h00);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h0AAAA, 8'hA5);
        do_op(1'b0, 17'h0AAAA, 8'h00);
        do_op(1'b1, 17'h0AAAA, 8'h5A);
        do_op(1'b1, 17'h15555, 8'h3C);
        do_op(1'b0, 17'h0AAAA, 8'h00);
        do_op(1'b0, 17'h15555, 8'h00);
        // Random mix in a small window plus the extremes
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            int sel;
            sel = $urandom() % 10;
            a = (sel == 0) ? 17'h1FFFF : (sel == 1) ? 17'h00000 : AW'($urandom() % 64);
            do_op($urandom() % 2 == 1, a, DW'($urandom()));
            if ($urandom() % 4 == 0) repeat ($urandom() % 3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule